// File: doc/BRIEF.md
# Dual-CPU Bus Control Translator

This block is the glue between two 8-bit processors with unlike bus styles and one shared memory and I/O system. The first processor style signals direction on a single read/write line and has a clock phase during which its address is trustworthy. The second style has separate active-low read and write strobes, plus a memory-request line that marks a stable address. Each style is converted into one neutral internal bus made of a read strobe, a write strobe, an address and write data. That neutral bus is then turned into a shared address and data bus, an output enable, a write enable and one chip select per memory region.

A select input chooses which processor is live. The other processor is held in its wait state and its bus inputs have no effect. An expansion port may request the bus for direct memory access. The request is granted only when the live processor is between bus cycles, and while the grant lasts the expansion port drives the shared bus. A collision flag from the dual-ported video and character memories stalls the live processor, through that processor's own wait mechanism, for as long as the flag is high.

Top module: `busxl_ctl`

## Requirements
- R1: `cpu_sel`=0 makes the single-line processor live and `cpu_sel`=1 makes the strobe processor live; the processor that is not live is held stalled (`a_rdy`=0 or `b_wait_n`=0) and its address, data and control inputs have no effect on any output.
- R2: For the single-line processor, a read is seen only while `a_phi2`=1 and `a_rw`=1, and a write only while `a_phi2`=1 and `a_rw`=0; with `a_phi2`=0 there is no strobe.
- R3: For the strobe processor, nothing is seen unless `b_mreq_n`=0; then `b_rd_n`=0 with `b_wr_n`=1 is a read and `b_wr_n`=0 with `b_rd_n`=1 is a write; both high or both low give no strobe.
- R4: A neutral read drives `oe_n` low and a neutral write drives `we_n` low; the two are never low together.
- R5: `cs_n` has one active-low select per region, asserted only during a read or write and never more than one: bit 0 main RAM for 0x0000-0xEFFF, bit 1 video RAM for 0xF000-0xF7FF, bit 2 character RAM for 0xF800-0xFBFF, bit 3 the I/O window for 0xFC00-0xFFFF.
- R6: While `mem_collide`=1 the live processor is stalled in the same cycle (`a_rdy`=0 and `b_wait_n`=0).
- R7: `dma_grant` rises at the clock edge where `dma_req`=1 and the live processor has no bus cycle open (`a_phi2`=0 for the single-line processor, `b_mreq_n`=1 for the strobe processor); it then stays high while `dma_req`=1 and falls at the first edge where `dma_req`=0.
- R8: While `dma_grant`=1 the processors' strobes are not passed on, `bus_addr` and `bus_wdata` come from `dma_addr` and `dma_wdata`, `dma_rd` alone is a read, `dma_wr` alone is a write, both or neither give no strobe, and the live processor is stalled.
- R9: While `dma_grant`=0, `bus_addr` and `bus_wdata` follow the live processor's address and write data.
- R10: Synchronous reset (`rst`=1) clears `dma_grant` regardless of `dma_req`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_sel | input | 1 | Live processor: 0 single-line style, 1 strobe style |
| a_addr | input | 16 | Single-line processor address |
| a_wdata | input | 8 | Single-line processor write data |
| a_rw | input | 1 | Single-line processor direction, 1 read, 0 write |
| a_phi2 | input | 1 | Single-line processor valid clock phase |
| a_rdy | output | 1 | Ready to the single-line processor, low stalls it |
| b_addr | input | 16 | Strobe processor address |
| b_wdata | input | 8 | Strobe processor write data |
| b_mreq_n | input | 1 | Strobe processor memory request, active low |
| b_rd_n | input | 1 | Strobe processor read strobe, active low |
| b_wr_n | input | 1 | Strobe processor write strobe, active low |
| b_wait_n | output | 1 | Wait to the strobe processor, low stalls it |
| dma_req | input | 1 | Expansion port bus request |
| dma_addr | input | 16 | Expansion port address |
| dma_wdata | input | 8 | Expansion port write data |
| dma_rd | input | 1 | Expansion port read request |
| dma_wr | input | 1 | Expansion port write request |
| dma_grant | output | 1 | Bus granted to the expansion port |
| mem_collide | input | 1 | Dual-port memory collision flag, active high |
| bus_addr | output | 16 | Shared address bus |
| bus_wdata | output | 8 | Shared write data bus |
| oe_n | output | 1 | Output enable, active low |
| we_n | output | 1 | Write enable, active low |
| cs_n | output | 4 | Region chip selects, active low |

## Verification
Almost all of this block is combinational, so a wrong strobe, select or stall appears at the ports in the very cycle its inputs are applied. The only stored state is the bus grant; a grant taken in the middle of a processor cycle, or held after the request drops, shows up one edge later as the shared address switching source and the live processor's ready or wait line going low. The sweep runs every control combination of both processors, the collision flag and the expansion port against addresses on each side of every region boundary, while a grant model in the bench follows the request history cycle by cycle.

// File: rtl/busxl_pkg.sv
package busxl_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;
    localparam int NUM_RGN = 4;

    // neutral bus carried between the front ends and the back end
    typedef struct packed {
        logic              rd;
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } xbus_t;

    typedef enum logic {
        CPU_LINE  = 1'b0,
        CPU_STRB  = 1'b1
    } cpu_t;

    function automatic logic win_hit(
        input logic [ADDR_W-1:0] a,
        input logic [ADDR_W-1:0] base,
        input logic [ADDR_W-1:0] mask
    );
        return (a & mask) == base;
    endfunction

    // a strobe pair is usable only when exactly one of them is active
    function automatic logic [1:0] strobe_pair(input logic rd_req, input logic wr_req);
        return {rd_req & ~wr_req, wr_req & ~rd_req};
    endfunction

endpackage

// File: rtl/busxl_front_line.sv
module busxl_front_line
    import busxl_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rw,
    input  logic              phi2,
    output logic              cyc_open,
    output xbus_t             nbus
);
    always_comb begin
        cyc_open   = phi2;
        nbus.addr  = addr;
        nbus.wdata = wdata;
        // write qualified by the clock phase so no write leaks outside it
        nbus.rd    = phi2 & rw;
        nbus.wr    = phi2 & ~rw;
    end
endmodule

// File: rtl/busxl_front_strb.sv
module busxl_front_strb
    import busxl_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              mreq_n,
    input  logic              rd_n,
    input  logic              wr_n,
    output logic              cyc_open,
    output xbus_t             nbus
);
    logic [1:0] pair;

    always_comb begin
        pair       = strobe_pair(~rd_n, ~wr_n);
        cyc_open   = ~mreq_n;
        nbus.addr  = addr;
        nbus.wdata = wdata;
        nbus.rd    = ~mreq_n & pair[1];
        nbus.wr    = ~mreq_n & pair[0];
    end
endmodule

// File: rtl/busxl_dma_arb.sv
module busxl_dma_arb (
    input  logic clk,
    input  logic rst,
    input  logic req,
    input  logic cpu_cyc_open,
    output logic grant
);
    logic grant_q;

    always_ff @(posedge clk) begin
        if (rst)
            grant_q <= 1'b0;
        else if (!req)
            grant_q <= 1'b0;
        else if (!cpu_cyc_open)
            grant_q <= 1'b1;
    end

    assign grant = grant_q;

    // R7: a new grant only follows a request seen at a cycle boundary
    assert_grant_at_boundary_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(grant) |-> ($past(req) && !$past(cpu_cyc_open)));

    // R7: a dropped request releases the bus at the next edge
    assert_grant_release_R7: assert property (@(posedge clk) disable iff (rst)
        !req |=> !grant);
endmodule

// File: rtl/busxl_decode.sv
module busxl_decode
    import busxl_pkg::*;
#(
    parameter int                          NWIN     = NUM_RGN - 1,
    parameter logic [NWIN*ADDR_W-1:0]      WIN_BASE = {16'hFC00, 16'hF800, 16'hF000},
    parameter logic [NWIN*ADDR_W-1:0]      WIN_MASK = {16'hFC00, 16'hFC00, 16'hF800}
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              active,
    output logic [NWIN:0]     cs_n
);
    logic [NWIN-1:0] hit;

    for (genvar i = 0; i < NWIN; i++) begin : g_win
        assign hit[i] = win_hit(addr,
                                WIN_BASE[i*ADDR_W +: ADDR_W],
                                WIN_MASK[i*ADDR_W +: ADDR_W]);
    end

    // lowest select is the default region: anything no window claims
    assign cs_n = ~({hit, ~|hit} & {(NWIN+1){active}});

    // R5: at most one region selected, and only during an access
    always_comb begin
        assert_single_select_R5: assert ($countones(~cs_n) <= 1);
        if (!active) assert_idle_no_select_R5: assert (&cs_n);
    end
endmodule

// File: rtl/busxl_ctl.sv
module busxl_ctl
    import busxl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_sel,
    input  logic [15:0]       a_addr,
    input  logic [7:0]        a_wdata,
    input  logic              a_rw,
    input  logic              a_phi2,
    output logic              a_rdy,
    input  logic [15:0]       b_addr,
    input  logic [7:0]        b_wdata,
    input  logic              b_mreq_n,
    input  logic              b_rd_n,
    input  logic              b_wr_n,
    output logic              b_wait_n,
    input  logic              dma_req,
    input  logic [15:0]       dma_addr,
    input  logic [7:0]        dma_wdata,
    input  logic              dma_rd,
    input  logic              dma_wr,
    output logic              dma_grant,
    input  logic              mem_collide,
    output logic [15:0]       bus_addr,
    output logic [7:0]        bus_wdata,
    output logic              oe_n,
    output logic              we_n,
    output logic [3:0]        cs_n
);
    xbus_t line_bus, strb_bus, cpu_bus, dma_bus, out_bus;
    logic  line_open, strb_open, cpu_open;
    logic  hold;
    logic  [1:0] dma_pair;
    cpu_t  live;

    busxl_front_line u_line (
        .addr(a_addr), .wdata(a_wdata), .rw(a_rw), .phi2(a_phi2),
        .cyc_open(line_open), .nbus(line_bus)
    );

    busxl_front_strb u_strb (
        .addr(b_addr), .wdata(b_wdata), .mreq_n(b_mreq_n),
        .rd_n(b_rd_n), .wr_n(b_wr_n),
        .cyc_open(strb_open), .nbus(strb_bus)
    );

    always_comb begin
        live     = cpu_t'(cpu_sel);
        cpu_bus  = (live == CPU_STRB) ? strb_bus : line_bus;
        cpu_open = (live == CPU_STRB) ? strb_open : line_open;
    end

    busxl_dma_arb u_arb (
        .clk(clk), .rst(rst), .req(dma_req),
        .cpu_cyc_open(cpu_open), .grant(dma_grant)
    );

    always_comb begin
        dma_pair      = strobe_pair(dma_rd, dma_wr);
        dma_bus.addr  = dma_addr;
        dma_bus.wdata = dma_wdata;
        dma_bus.rd    = dma_pair[1];
        dma_bus.wr    = dma_pair[0];
        out_bus       = dma_grant ? dma_bus : cpu_bus;
    end

    assign bus_addr  = out_bus.addr;
    assign bus_wdata = out_bus.wdata;
    assign oe_n      = ~out_bus.rd;
    assign we_n      = ~out_bus.wr;

    busxl_decode u_dec (
        .addr(out_bus.addr),
        .active(out_bus.rd | out_bus.wr),
        .cs_n(cs_n)
    );

    assign hold     = dma_grant | mem_collide;
    assign a_rdy    = (live == CPU_LINE) & ~hold;
    assign b_wait_n = (live == CPU_STRB) & ~hold;

    // R4: enables are mutually exclusive
    assert_strobe_excl_R4: assert property (@(posedge clk) disable iff (rst)
        !(!oe_n && !we_n));

    // R6: a collision stalls both ready lines
    assert_collide_stall_R6: assert property (@(posedge clk) disable iff (rst)
        mem_collide |-> (!a_rdy && !b_wait_n));

    // R1: at most one processor is ever released
    assert_one_live_R1: assert property (@(posedge clk) disable iff (rst)
        $onehot0({a_rdy, b_wait_n}));

    // R8: an idle expansion port keeps the bus quiet while it owns it
    assert_dma_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        (dma_grant && !dma_rd && !dma_wr) |-> (oe_n && we_n && &cs_n));

    // R8: owner of the bus is never released to run
    assert_dma_stall_R8: assert property (@(posedge clk) disable iff (rst)
        dma_grant |-> (!a_rdy && !b_wait_n));
endmodule

// File: tb/busxl_ctl_test.sv
module busxl_ctl_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        cpu_sel;
    logic [15:0] a_addr, b_addr, dma_addr;
    logic [7:0]  a_wdata, b_wdata, dma_wdata;
    logic        a_rw, a_phi2, b_mreq_n, b_rd_n, b_wr_n;
    logic        dma_req, dma_rd, dma_wr, mem_collide;
    logic        a_rdy, b_wait_n, dma_grant, oe_n, we_n;
    logic [15:0] bus_addr;
    logic [7:0]  bus_wdata;
    logic [3:0]  cs_n;

    int vectors = 0;
    int fails   = 0;
    logic g_exp = 1'b0;
    logic done  = 1'b0;

    always #10 clk = ~clk;

    busxl_ctl uut (
        .clk(clk), .rst(rst), .cpu_sel(cpu_sel),
        .a_addr(a_addr), .a_wdata(a_wdata), .a_rw(a_rw), .a_phi2(a_phi2), .a_rdy(a_rdy),
        .b_addr(b_addr), .b_wdata(b_wdata), .b_mreq_n(b_mreq_n), .b_rd_n(b_rd_n),
        .b_wr_n(b_wr_n), .b_wait_n(b_wait_n),
        .dma_req(dma_req), .dma_addr(dma_addr), .dma_wdata(dma_wdata),
        .dma_rd(dma_rd), .dma_wr(dma_wr), .dma_grant(dma_grant),
        .mem_collide(mem_collide), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .oe_n(oe_n), .we_n(we_n), .cs_n(cs_n)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [1:0] region_of(input logic [15:0] a);
        if (a < 16'hF000)      return 2'd0;
        else if (a < 16'hF800) return 2'd1;
        else if (a < 16'hFC00) return 2'd2;
        else                   return 2'd3;
    endfunction

    function automatic logic cpu_open_now();
        return cpu_sel ? !b_mreq_n : a_phi2;
    endfunction

    task automatic check_cycle();
        logic rd, wr;
        logic [15:0] ea;
        logic [7:0]  ed;
        logic [3:0]  ecs;
        string stag, atag, htag;
        if (g_exp) begin
            rd = dma_rd && !dma_wr;
            wr = dma_wr && !dma_rd;
            ea = dma_addr; ed = dma_wdata;
            stag = "R8"; atag = "R8";
        end else if (cpu_sel) begin
            rd = !b_mreq_n && !b_rd_n && b_wr_n;
            wr = !b_mreq_n && !b_wr_n && b_rd_n;
            ea = b_addr; ed = b_wdata;
            stag = "R3"; atag = "R9";
        end else begin
            rd = a_phi2 && a_rw;
            wr = a_phi2 && !a_rw;
            ea = a_addr; ed = a_wdata;
            stag = "R2"; atag = "R9";
        end
        ecs = (rd || wr) ? ~(4'b0001 << region_of(ea)) : 4'hF;
        htag = mem_collide ? "R6" : (g_exp ? "R8" : "R1");
        vectors++;
        chk("R7", "dma_grant", dma_grant, g_exp);
        chk(stag, "oe_n", oe_n, !rd);
        chk(stag, "we_n", we_n, !wr);
        chk("R4", "oe_n&we_n low", !oe_n && !we_n, 1'b0);
        chk("R5", "cs_n", cs_n, ecs);
        chk(atag, "bus_addr", bus_addr, ea);
        chk(atag, "bus_wdata", bus_wdata, ed);
        chk(htag, "a_rdy", a_rdy, !cpu_sel && !g_exp && !mem_collide);
        chk(htag, "b_wait_n", b_wait_n, cpu_sel && !g_exp && !mem_collide);
    endtask

    initial begin
        logic [15:0] pts [8];
        pts = '{16'h0000, 16'hEFFF, 16'hF000, 16'hF7F8,
                16'hF800, 16'hFBF8, 16'hFC00, 16'hFFF8};
        rst = 1'b1; cpu_sel = 1'b0;
        a_addr = 16'h0; b_addr = 16'h0; dma_addr = 16'h0;
        a_wdata = 8'h0; b_wdata = 8'h0; dma_wdata = 8'h0;
        a_rw = 1'b1; a_phi2 = 1'b0; b_mreq_n = 1'b1; b_rd_n = 1'b1; b_wr_n = 1'b1;
        dma_req = 1'b1; dma_rd = 1'b0; dma_wr = 1'b0; mem_collide = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        vectors++;
        chk("R10", "dma_grant in reset", dma_grant, 1'b0);
        dma_req = 1'b0;
        rst = 1'b0;
        g_exp = 1'b0;
        for (int v = 0; v < 1024; v++) begin
            for (int k = 0; k < 8; k++) begin
                @(negedge clk);
                cpu_sel     = v[0];
                a_rw        = v[1];
                a_phi2      = v[2];
                b_mreq_n    = v[3];
                b_rd_n      = v[4];
                b_wr_n      = v[5];
                mem_collide = v[6];
                dma_req     = v[7];
                dma_rd      = v[8];
                dma_wr      = v[9];
                a_addr      = pts[k];
                b_addr      = pts[k] ^ 16'h0002;
                dma_addr    = pts[(k + 3) % 8] ^ 16'h0004;
                a_wdata     = pts[k][7:0] ^ 8'h11 ^ 8'(v);
                b_wdata     = pts[k][7:0] ^ 8'h22 ^ 8'(v);
                dma_wdata   = pts[k][7:0] ^ 8'h33 ^ 8'(v);
                #5;
                check_cycle();
                @(posedge clk);
                g_exp = dma_req && (g_exp || !cpu_open_now());
            end
        end
        // R7: request raised mid-cycle is held off until the cycle closes
        @(negedge clk);
        cpu_sel = 1'b1; b_mreq_n = 1'b0; b_rd_n = 1'b0; b_wr_n = 1'b1;
        mem_collide = 1'b0; dma_req = 1'b0; dma_rd = 1'b0; dma_wr = 1'b0;
        @(negedge clk);
        dma_req = 1'b1;
        @(negedge clk);
        #5; vectors++;
        chk("R7", "grant held off in open cycle", dma_grant, 1'b0);
        b_mreq_n = 1'b1;
        @(negedge clk);
        #5; vectors++;
        chk("R7", "grant after cycle closes", dma_grant, 1'b1);
        b_mreq_n = 1'b0;
        @(negedge clk);
        #5; vectors++;
        chk("R8", "CPU strobe blocked under grant", {oe_n, we_n}, 2'b11);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not complete, got hang expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule